// File: doc/BRIEF.md
# Wide Address-Translation Root Register

This block holds the supervisor address-translation control register of a core with a 128-bit register width. The register is kept as a low and a high 64-bit half. The high half carries the translation scheme selector and the address-space identifier. The low half carries the physical page number of the root page table. The block presents these three fields to the page-table walker.

A CSR access arrives as a single-cycle request. The request carries the current privilege level, the trap-virtual-memory status bit and a strap that says whether address translation hardware exists. One cycle later the block answers with a response strobe, read data and an illegal-instruction flag. The block decides whether a write commits. It checks that the requested scheme is one it supports and that some field really changes. It also raises a one-cycle TLB flush request when a committed write alters the address-space identifier.

Top module: `xlat_root_ctrl`

## Requirements
- R1: After reset the stored value is all zeros, so the scheme field reads 0 (bare). The response strobe and the flush request are low.
- R2: The scheme field is bits 63:56 of the high half and the identifier is bits 55:24 of the high half. The root page number is bits 49:0 of the low half. After a committed write, the walker outputs show the new fields in the cycle the response appears.
- R3: A scheme counts as legal when its low 4 bits are 0 (bare), 12 (3-level, 16 KiB pages) or 13 (4-level, 16 KiB pages); bits 7:4 are not looked at. A write with an illegal scheme changes nothing, raises no exception and raises no flush.
- R4: A write whose new value equals the stored value on the scheme, identifier and page-number bits is dropped. This holds even when other bits differ, and such a write raises no exception even when trapping is active.
- R5: When privilege is supervisor (encoding 2'b01) and the trap bit is set, the illegal flag is raised and the read data is zero. This applies to every read and to every write that would otherwise commit, and the stored value is left unchanged.
- R6: A committed write that changes any identifier bit raises the flush request for exactly one cycle, together with the response. A committed write that changes only the scheme or the page number raises no flush.
- R7: With the translation strap low, reads return zero and writes neither change the register nor raise an exception.
- R8: A committed write stores all 128 bits exactly as written, including bits outside the three fields. A later read returns them.
- R9: The response strobe rises in the cycle after each request. The read data of an allowed access is the value held before that request.
- R10: In a cycle after a cycle with no request, the response strobe and the flush request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CSR access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata_lo | input | 64 | Write data, low half |
| req_wdata_hi | input | 64 | Write data, high half |
| cur_priv | input | 2 | Current privilege level (2'b01 supervisor) |
| trap_vm | input | 1 | Trap-virtual-memory status bit |
| xlat_present | input | 1 | Strap: translation hardware exists |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_illegal | output | 1 | Illegal-instruction indication |
| rsp_rdata_lo | output | 64 | Read data, low half |
| rsp_rdata_hi | output | 64 | Read data, high half |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| walk_mode | output | 8 | Scheme field to the walker |
| walk_asid | output | 32 | Address-space identifier to the walker |
| walk_root_ppn | output | 50 | Root page-table page number to the walker |

## Verification
The assertions assume that the request inputs are steady for the whole clock cycle they are sampled in. They also assume that the privilege, trap and strap inputs are only meaningful while a request is present. The stimulus drives every input at the falling edge and holds it through the next rising edge. It drops the request between accesses so that idle cycles appear. Random scheme values are biased toward the three legal codes and toward rewrites of the stored value, so that the no-change and trapped paths are exercised along with arbitrary illegal codes.

// File: rtl/xlat_root_pkg.sv
package xlat_root_pkg;
    localparam int HALF_W     = 64;
    localparam int MODE_LSB   = 56;
    localparam int MODE_W     = 8;
    localparam int ASID_LSB   = 24;
    localparam int ASID_W     = 32;
    localparam int PPN_W      = 50;
    localparam int LOOKUP_W   = 4;
    localparam int LOOKUP_N   = 1 << LOOKUP_W;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    // one bit per low-nibble code: 0 bare, 12 three-level, 13 four-level
    localparam logic [LOOKUP_N-1:0] LEGAL_CODES = LOOKUP_N'((1 << 0) | (1 << 12) | (1 << 13));

    typedef struct packed {
        logic [HALF_W-1:0] reg_lo;
        logic [HALF_W-1:0] reg_hi;
        logic              rsp_valid;
        logic              rsp_illegal;
        logic [HALF_W-1:0] rdata_lo;
        logic [HALF_W-1:0] rdata_hi;
        logic              flush;
    } ctrl_state_t;
endpackage

// File: rtl/xlat_mode_check.sv
module xlat_mode_check
    import xlat_root_pkg::*;
#(
    parameter int              SEL_W = LOOKUP_W,
    parameter logic [(1<<SEL_W)-1:0] LEGAL = LEGAL_CODES
) (
    input  logic [SEL_W-1:0] code,
    output logic             legal
);
    always_comb legal = LEGAL[code];
endmodule

// File: rtl/xlat_field_diff.sv
module xlat_field_diff
    import xlat_root_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic [W-1:0] new_lo,
    input  logic [W-1:0] new_hi,
    input  logic [W-1:0] old_lo,
    input  logic [W-1:0] old_hi,
    output logic         any_change,
    output logic         asid_change
);
    localparam logic [W-1:0] PPN_MASK  = W'((65'd1 << PPN_W) - 65'd1);
    localparam logic [W-1:0] ASID_MASK = W'(((65'd1 << ASID_W) - 65'd1) << ASID_LSB);
    localparam logic [W-1:0] MODE_MASK = W'(((65'd1 << MODE_W) - 65'd1) << MODE_LSB);
    localparam logic [W-1:0] HI_MASK   = ASID_MASK | MODE_MASK;

    logic [W-1:0] diff_lo, diff_hi;

    always_comb begin
        diff_lo     = (new_lo ^ old_lo) & PPN_MASK;
        diff_hi     = (new_hi ^ old_hi) & HI_MASK;
        any_change  = |{diff_lo, diff_hi};
        asid_change = |(diff_hi & ASID_MASK);
    end
endmodule

// File: rtl/xlat_root_ctrl.sv
module xlat_root_ctrl
    import xlat_root_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [HALF_W-1:0]   req_wdata_lo,
    input  logic [HALF_W-1:0]   req_wdata_hi,
    input  logic [1:0]          cur_priv,
    input  logic                trap_vm,
    input  logic                xlat_present,
    output logic                rsp_valid,
    output logic                rsp_illegal,
    output logic [HALF_W-1:0]   rsp_rdata_lo,
    output logic [HALF_W-1:0]   rsp_rdata_hi,
    output logic                tlb_flush,
    output logic [MODE_W-1:0]   walk_mode,
    output logic [ASID_W-1:0]   walk_asid,
    output logic [PPN_W-1:0]    walk_root_ppn
);
    ctrl_state_t st_d, st_q;
    logic mode_ok, fields_differ, asid_differs;
    logic trapped, qualifies;

    xlat_mode_check u_mode (
        .code  (req_wdata_hi[MODE_LSB +: LOOKUP_W]),
        .legal (mode_ok)
    );

    xlat_field_diff u_diff (
        .new_lo      (req_wdata_lo),
        .new_hi      (req_wdata_hi),
        .old_lo      (st_q.reg_lo),
        .old_hi      (st_q.reg_hi),
        .any_change  (fields_differ),
        .asid_change (asid_differs)
    );

    always_comb begin
        st_d             = st_q;
        st_d.rsp_valid   = req_valid;
        st_d.rsp_illegal = 1'b0;
        st_d.rdata_lo    = '0;
        st_d.rdata_hi    = '0;
        st_d.flush       = 1'b0;
        trapped   = (cur_priv == PRIV_SUPER) && trap_vm;
        qualifies = mode_ok && fields_differ;

        if (req_valid && xlat_present) begin
            if (!req_write) begin
                if (trapped) begin
                    st_d.rsp_illegal = 1'b1;
                end else begin
                    st_d.rdata_lo = st_q.reg_lo;
                    st_d.rdata_hi = st_q.reg_hi;
                end
            end else if (qualifies && trapped) begin
                st_d.rsp_illegal = 1'b1;
            end else begin
                st_d.rdata_lo = st_q.reg_lo;
                st_d.rdata_hi = st_q.reg_hi;
                if (qualifies) begin
                    st_d.reg_lo = req_wdata_lo;
                    st_d.reg_hi = req_wdata_hi;
                    st_d.flush  = asid_differs;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_illegal   = st_q.rsp_illegal;
    assign rsp_rdata_lo  = st_q.rdata_lo;
    assign rsp_rdata_hi  = st_q.rdata_hi;
    assign tlb_flush     = st_q.flush;
    assign walk_mode     = st_q.reg_hi[MODE_LSB +: MODE_W];
    assign walk_asid     = st_q.reg_hi[ASID_LSB +: ASID_W];
    assign walk_root_ppn = st_q.reg_lo[PPN_W-1:0];
endmodule

// File: rtl/xlat_root_chk.sv
module xlat_root_chk
    import xlat_root_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [HALF_W-1:0]   req_wdata_hi,
    input logic                xlat_present,
    input logic                rsp_valid,
    input logic                rsp_illegal,
    input logic [HALF_W-1:0]   rsp_rdata_lo,
    input logic [HALF_W-1:0]   rsp_rdata_hi,
    input logic                tlb_flush,
    input logic [MODE_W-1:0]   walk_mode,
    input logic [ASID_W-1:0]   walk_asid,
    input logic [PPN_W-1:0]    walk_root_ppn
);
    logic [3:0] nib;
    logic       nib_ok;
    assign nib    = req_wdata_hi[MODE_LSB +: 4];
    assign nib_ok = (nib == 4'd0) || (nib == 4'd12) || (nib == 4'd13);

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !tlb_flush)); // R10
    AST_FLUSH_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> (rsp_valid && !rsp_illegal)); // R6
    AST_ILLEGAL_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> ($stable(walk_mode) && $stable(walk_asid) && $stable(walk_root_ppn)
                         && rsp_rdata_lo == '0 && rsp_rdata_hi == '0)); // R5
    AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !nib_ok) |=>
            ($stable(walk_mode) && $stable(walk_asid) && $stable(walk_root_ppn)
             && !rsp_illegal && !tlb_flush)); // R3
    AST_NO_XLAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_present) |=>
            (!rsp_illegal && !tlb_flush && rsp_rdata_lo == '0 && rsp_rdata_hi == '0
             && $stable(walk_mode) && $stable(walk_asid) && $stable(walk_root_ppn))); // R7
endmodule

bind xlat_root_ctrl xlat_root_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_wdata_hi  (req_wdata_hi),
    .xlat_present  (xlat_present),
    .rsp_valid     (rsp_valid),
    .rsp_illegal   (rsp_illegal),
    .rsp_rdata_lo  (rsp_rdata_lo),
    .rsp_rdata_hi  (rsp_rdata_hi),
    .tlb_flush     (tlb_flush),
    .walk_mode     (walk_mode),
    .walk_asid     (walk_asid),
    .walk_root_ppn (walk_root_ppn)
);

// File: tb/tb_xlat_root_ctrl.sv
module tb_xlat_root_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [63:0] req_wdata_lo = '0, req_wdata_hi = '0;
    logic [1:0]  cur_priv = 2'b11;
    logic        trap_vm = 1'b0, xlat_present = 1'b1;
    logic        rsp_valid, rsp_illegal, tlb_flush;
    logic [63:0] rsp_rdata_lo, rsp_rdata_hi;
    logic [7:0]  walk_mode;
    logic [31:0] walk_asid;
    logic [49:0] walk_root_ppn;

    int n_vec = 0, n_bad = 0;
    logic [63:0] m_lo = '0, m_hi = '0;

    always #2 clk = ~clk;

    xlat_root_ctrl dut (.*);

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic mode_legal(input logic [63:0] hi);
        logic [3:0] n = hi[59:56];
        return n == 4'd0 || n == 4'd12 || n == 4'd13;
    endfunction

    function automatic logic fields_differ(input logic [63:0] lo, input logic [63:0] hi);
        return ((lo ^ m_lo) & 64'h0003_FFFF_FFFF_FFFF) != 0 ||
               ((hi ^ m_hi) & 64'hFFFF_FFFF_FF00_0000) != 0;
    endfunction

    task automatic access(input logic wr, input logic [63:0] lo, input logic [63:0] hi,
                          input logic [1:0] pv, input logic tv, input logic mm);
        logic trap, qual, e_ill, e_fl;
        logic [127:0] e_rd;
        trap  = (pv == 2'b01) && tv;
        qual  = mode_legal(hi) && fields_differ(lo, hi);
        e_ill = 1'b0; e_fl = 1'b0; e_rd = '0;
        if (mm) begin
            if (!wr) begin
                if (trap) e_ill = 1'b1; else e_rd = {m_hi, m_lo};
            end else if (qual && trap) e_ill = 1'b1;
            else e_rd = {m_hi, m_lo};
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata_lo = lo; req_wdata_hi = hi;
        cur_priv = pv; trap_vm = tv; xlat_present = mm;
        @(negedge clk);
        req_valid = 1'b0;
        if (mm && wr && qual && !trap) begin
            e_fl = ((hi ^ m_hi) & 64'h00FF_FFFF_FF00_0000) != 0;
            m_lo = lo; m_hi = hi;
        end
        check("R9 rsp_valid", 128'(rsp_valid), 128'd1);
        check("R5 illegal", 128'(rsp_illegal), 128'(e_ill));
        check("R9 rdata", {rsp_rdata_hi, rsp_rdata_lo}, e_rd);
        check("R6 flush", 128'(tlb_flush), 128'(e_fl));
        check("R2 fields", 128'({walk_mode, walk_asid, walk_root_ppn}),
              128'({m_hi[63:56], m_hi[55:24], m_lo[49:0]}));
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R10 idle rsp", 128'(rsp_valid), 128'd0);
        check("R10 idle flush", 128'(tlb_flush), 128'd0);
    endtask

    initial begin
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset fields", 128'({walk_mode, walk_asid, walk_root_ppn}), 128'd0);
        check("R1 reset rsp", 128'({rsp_valid, tlb_flush}), 128'd0);
        access(0, 0, 0, 2'b11, 0, 1);
        // R2 R6 R8: commit with new ASID, full 128 bits incl. unused bits
        access(1, 64'hFFF0_0000_0000_1234, 64'h0C00_00AB_CD00_00F7, 2'b11, 0, 1);
        access(0, 0, 0, 2'b00, 0, 1); // R8 readback
        // R6: change only PPN -> no flush
        access(1, 64'h0000_0000_0000_5555, 64'h0C00_00AB_CD00_00F7, 2'b01, 0, 1);
        // R6: change only mode 12->13 -> no flush
        access(1, 64'h0000_0000_0000_5555, 64'h0D00_00AB_CD00_00F7, 2'b11, 0, 1);
        // R3: illegal mode 9 ignored; high-nibble set with nibble 12 is legal
        access(1, 64'h1, 64'h0900_0011_0000_0000, 2'b11, 0, 1);
        access(1, 64'h2, 64'hFC00_0022_0000_0000, 2'b11, 0, 1);
        // R4: only non-field bits differ -> dropped, even when trapped
        access(1, 64'hABC0_0000_0000_0002, 64'hFC00_0022_0000_1234, 2'b01, 1, 1);
        access(0, 0, 0, 2'b11, 0, 1);
        // R5: trapped read and trapped qualifying write
        access(0, 0, 0, 2'b01, 1, 1);
        access(1, 64'h7, 64'h0D00_0099_0000_0000, 2'b01, 1, 1);
        // R5: trap bit ignored at machine level
        access(1, 64'h7, 64'h0D00_0099_0000_0000, 2'b11, 1, 1);
        // R7: no translation hardware
        access(0, 0, 0, 2'b11, 0, 0);
        access(1, 64'h9, 64'h0C00_1234_5600_0000, 2'b01, 1, 0);
        idle_check();
        // R1 back to bare
        access(1, 0, 0, 2'b11, 0, 1);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] lo, hi;
            logic [3:0]  sel;
            lo = {$urandom, $urandom};
            hi = {$urandom, $urandom};
            sel = 4'($urandom % 8);
            case (sel)
                4'd0: hi[59:56] = 4'd0;
                4'd1: hi[59:56] = 4'd12;
                4'd2: hi[59:56] = 4'd13;
                4'd3: begin lo = m_lo; hi = m_hi; end
                4'd4: begin lo = m_lo ^ 64'hC000_0000_0000_0000; hi = m_hi ^ 64'h0000_0000_00FF_FFFF; end
                4'd5: begin hi = m_hi; hi[59:56] = 4'd13; end
                default: ;
            endcase
            access(1'($urandom), lo, hi, 2'($urandom), 1'($urandom), ($urandom % 8) != 0);
            if (i % 37 == 0) idle_check();
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule